// File: doc/BRIEF.md
# Execute Stage Operand Select ALU

This block is the execute stage of a five-stage 32-bit RISC pipeline. Each cycle it takes the fields held in the decode/execute pipeline latch: the next-PC value, the two register operands, the sign-extended immediate and the complete instruction word. The opcode alone steers two operand multiplexers. The first operand is the next-PC for control-transfer instructions and register A for all others. The second operand is register B for register-register instructions and the immediate for all others.

The opcode selects the ALU operation. For register-register instructions the low function field also takes part in that choice. The block registers two outputs. One is the ALU result. The other is a one-bit condition flag that a later stage uses to decide whether a conditional branch is taken. The flag comes from a test of register A against zero, not from the ALU result. Both outputs load on a rising edge while the stage enable is high, and a synchronous reset clears them. The block does no hazard detection, forwarding, memory access or register writeback.

The instruction is numbered with bit 0 as the most significant bit. In little-endian indexing the opcode is therefore `instr_i[31:26]` and the function field is `instr_i[10:0]`.

Top module: `ex_opsel_alu`

## Requirements
- R1: While `rst` is high at a rising edge, `result_o` becomes 0 and `cond_o` becomes 0 at that edge.
- R2: While `en` is low and `rst` is low, a rising edge leaves `result_o` and `cond_o` unchanged, whatever the data inputs are.
- R3: For opcode `instr_i[31:26]` equal to 6'h02 or 6'h03 (jump) or to 6'h04 or 6'h05 (branch), the first ALU operand is `npc_i` and the result is `npc_i + imm_i`. For every other opcode the first operand is `opa_i`.
- R4: For opcode 6'h00 (register-register) the second operand is `opb_i`. For every other opcode it is `imm_i`.
- R5: For opcode 6'h00 the 11-bit function field `instr_i[10:0]` selects the operation. 11'h020 is add, 11'h022 is sub (first minus second), 11'h024 is and, 11'h025 is or and 11'h026 is xor. 11'h004 is a logical left shift, 11'h006 a logical right shift and 11'h007 an arithmetic right shift, each of the first operand by `opb_i[4:0]`. 11'h02A is a signed set-less-than that gives 1 or 0.
- R6: For opcode 6'h00 with any function value not listed in R5, the result is 0.
- R7: For the non-register, non-control opcodes, 6'h0C gives A and immediate, 6'h0D gives A or immediate, 6'h0E gives A xor immediate and 6'h0A gives a signed set-less-than of A against the immediate. Every other opcode gives A plus immediate.
- R8: `cond_o` is 1 for opcode 6'h04 when `opa_i` is zero and for opcode 6'h05 when `opa_i` is nonzero. For every other opcode it is 0.
- R9: Inputs present at an enabled rising edge appear on `result_o` and `cond_o` after that same edge, one cycle of latency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Stage enable; outputs load only when high |
| npc_i | input | 32 | Next-PC from the pipeline latch |
| opa_i | input | 32 | Register operand A |
| opb_i | input | 32 | Register operand B |
| imm_i | input | 32 | Sign-extended immediate |
| instr_i | input | 32 | Full instruction word |
| result_o | output | 32 | Registered ALU result |
| cond_o | output | 1 | Registered branch condition flag |

## Verification
The only state in the block is the two output registers, so any wrong internal value shows up at the ports one edge after the instruction that caused it. A wrong operand select or a wrong operation decode gives a wrong `result_o` on the next sample. A flag that tracks the wrong comparison gives a wrong `cond_o` on the next sample. An enable or reset that fails to hold the registers shows as outputs that change while the stage is stalled, or that stay nonzero after reset. The bench therefore compares both outputs after every edge, for random instructions and for directed corner cases.

// File: rtl/ex_opsel_alu.sv
module ex_opsel_alu (
  input  logic        clk,
  input  logic        rst,
  input  logic        en,
  input  logic [31:0] npc_i,
  input  logic [31:0] opa_i,
  input  logic [31:0] opb_i,
  input  logic [31:0] imm_i,
  input  logic [31:0] instr_i,
  output logic [31:0] result_o,
  output logic        cond_o
);

  localparam logic [5:0]  OP_REG  = 6'h00, OP_J = 6'h02, OP_JL = 6'h03,
                          OP_BZ   = 6'h04, OP_BNZ = 6'h05, OP_SLTI = 6'h0A,
                          OP_ANDI = 6'h0C, OP_ORI = 6'h0D, OP_XORI = 6'h0E;
  localparam logic [10:0] F_ADD = 11'h020, F_SUB = 11'h022, F_AND = 11'h024,
                          F_OR  = 11'h025, F_XOR = 11'h026, F_SLL = 11'h004,
                          F_SRL = 11'h006, F_SRA = 11'h007, F_SLT = 11'h02A;

  wire [5:0]  opc    = instr_i[31:26];
  wire [10:0] fn     = instr_i[10:0];
  wire        is_reg = (opc == OP_REG);
  wire        is_ctl = (opc == OP_J) || (opc == OP_JL) || (opc == OP_BZ) || (opc == OP_BNZ);

  wire [31:0] x = is_ctl ? npc_i : opa_i;
  wire [31:0] y = is_reg ? opb_i : imm_i;
  wire [4:0]  sh = y[4:0];
  wire        lt = $signed(x) < $signed(y);

  logic [31:0] alu;
  logic        cnd;

  always_comb begin
    alu = x + y;
    if (is_reg) begin
      case (fn)
        F_ADD:   alu = x + y;
        F_SUB:   alu = x - y;
        F_AND:   alu = x & y;
        F_OR:    alu = x | y;
        F_XOR:   alu = x ^ y;
        F_SLL:   alu = x << sh;
        F_SRL:   alu = x >> sh;
        F_SRA:   alu = $unsigned($signed(x) >>> sh);
        F_SLT:   alu = {31'd0, lt};
        default: alu = '0;
      endcase
    end else begin
      case (opc)
        OP_ANDI: alu = x & y;
        OP_ORI:  alu = x | y;
        OP_XORI: alu = x ^ y;
        OP_SLTI: alu = {31'd0, lt};
        default: alu = x + y;
      endcase
    end
  end

  always_comb begin
    case (opc)
      OP_BZ:   cnd = (opa_i == '0);
      OP_BNZ:  cnd = (opa_i != '0);
      default: cnd = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      result_o <= '0;
      cond_o   <= 1'b0;
    end else if (en) begin
      result_o <= alu;
      cond_o   <= cnd;
    end
  end

  assert_reset_clear_R1: assert property (@(posedge clk)
    rst |=> (result_o == 32'd0 && !cond_o));

  assert_stall_hold_R2: assert property (@(posedge clk) disable iff (rst)
    !en |=> ($stable(result_o) && $stable(cond_o)));

  assert_ctl_target_R3: assert property (@(posedge clk) disable iff (rst)
    (en && instr_i[31:28] == 4'h0 && instr_i[27:26] != 2'b00 && instr_i[31:26] != 6'h01)
      |=> result_o == $past(npc_i) + $past(imm_i));

  assert_bad_func_zero_R6: assert property (@(posedge clk) disable iff (rst)
    (en && instr_i[31:26] == 6'h00 &&
     !(instr_i[10:0] inside {11'h020, 11'h022, 11'h024, 11'h025, 11'h026,
                             11'h004, 11'h006, 11'h007, 11'h02A}))
      |=> result_o == 32'd0);

  assert_bnz_flag_R8: assert property (@(posedge clk) disable iff (rst)
    (en && instr_i[31:26] == 6'h05) |=> cond_o == ($past(opa_i) != 32'd0));

  assert_bz_flag_R8: assert property (@(posedge clk) disable iff (rst)
    (en && instr_i[31:26] == 6'h04) |=> cond_o == ($past(opa_i) == 32'd0));

  assert_flag_quiet_R8: assert property (@(posedge clk) disable iff (rst)
    (en && instr_i[31:27] != 5'b00010) |=> !cond_o);

endmodule

// File: tb/ex_opsel_alu_tb_top.sv
module ex_opsel_alu_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        en  = 1'b0;
  logic [31:0] npc_i = '0, opa_i = '0, opb_i = '0, imm_i = '0, instr_i = '0;
  logic [31:0] result_o;
  logic        cond_o;

  int checks = 0;
  int fails  = 0;

  always #10 clk = ~clk;

  ex_opsel_alu dut_i (
    .clk(clk), .rst(rst), .en(en), .npc_i(npc_i), .opa_i(opa_i), .opb_i(opb_i),
    .imm_i(imm_i), .instr_i(instr_i), .result_o(result_o), .cond_o(cond_o)
  );

  function automatic logic [32:0] model(input logic [31:0] ins, n, a, b, im);
    logic [5:0]  op = ins[31:26];
    logic [10:0] f  = ins[10:0];
    logic [31:0] p, q, r;
    logic        c;
    p = (op >= 6'h02 && op <= 6'h05) ? n : a;
    q = (op == 6'h00) ? b : im;
    if (op == 6'h00) begin
      case (f)
        11'h020: r = p + q;
        11'h022: r = p - q;
        11'h024: r = p & q;
        11'h025: r = p | q;
        11'h026: r = p ^ q;
        11'h004: r = p << q[4:0];
        11'h006: r = p >> q[4:0];
        11'h007: r = $unsigned($signed(p) >>> q[4:0]);
        11'h02A: r = ($signed(p) < $signed(q)) ? 32'd1 : 32'd0;
        default: r = 32'd0;
      endcase
    end else if (op == 6'h0C) r = p & q;
    else if (op == 6'h0D) r = p | q;
    else if (op == 6'h0E) r = p ^ q;
    else if (op == 6'h0A) r = ($signed(p) < $signed(q)) ? 32'd1 : 32'd0;
    else r = p + q;
    c = (op == 6'h04) ? (a == 0) : (op == 6'h05) ? (a != 0) : 1'b0;
    return {c, r};
  endfunction

  function automatic string tag(input logic [31:0] ins);
    logic [5:0] op = ins[31:26];
    if (op == 6'h00)
      return (ins[10:0] inside {11'h020, 11'h022, 11'h024, 11'h025, 11'h026,
                                11'h004, 11'h006, 11'h007, 11'h02A}) ? "R4/R5" : "R6";
    if (op >= 6'h02 && op <= 6'h05) return "R3/R8";
    return "R7";
  endfunction

  task automatic compare(input string req, input logic [32:0] exp);
    checks++;
    if ({cond_o, result_o} !== exp) begin
      fails++;
      $display("FAIL %s: got cond=%0b result=%h, expected cond=%0b result=%h",
               req, cond_o, result_o, exp[32], exp[31:0]);
    end
  endtask

  task automatic issue(input logic [31:0] ins, n, a, b, im);
    logic [32:0] exp;
    instr_i = ins; npc_i = n; opa_i = a; opb_i = b; imm_i = im; en = 1'b1;
    exp = model(ins, n, a, b, im);
    @(posedge clk); @(negedge clk);
    compare({tag(ins), " R9"}, exp);
  endtask

  function automatic logic [31:0] rfn(input logic [10:0] f);
    return {6'h00, 15'h1234, f};
  endfunction

  initial begin
    logic [32:0] held;
    void'($urandom(32'd2024));
    @(negedge clk); @(negedge clk);
    compare("R1 reset", 33'd0);
    rst = 1'b0;

    issue(rfn(11'h020), 32'h100, 32'h7FFF_FFFF, 32'd1, 32'h5);
    issue(rfn(11'h022), 32'h100, 32'd3, 32'd5, 32'h5);
    issue(rfn(11'h007), 32'h0, 32'h8000_0010, 32'h0000_0024, 32'h0);
    issue(rfn(11'h006), 32'h0, 32'h8000_0010, 32'h0000_001F, 32'h0);
    issue(rfn(11'h004), 32'h0, 32'h0000_0003, 32'h0000_0021, 32'h0);
    issue(rfn(11'h02A), 32'h0, 32'hFFFF_FFFF, 32'd0, 32'h0);
    issue(rfn(11'h420), 32'h0, 32'd9, 32'd9, 32'd9);
    issue({6'h04, 26'h0}, 32'h400, 32'd0, 32'd7, 32'hFFFF_FFF0);
    issue({6'h04, 26'h0}, 32'h400, 32'd1, 32'd7, 32'h10);
    issue({6'h05, 26'h0}, 32'h400, 32'd0, 32'd7, 32'h10);
    issue({6'h05, 26'h0}, 32'h400, 32'h8000_0000, 32'd7, 32'h10);
    issue({6'h02, 26'h0}, 32'h800, 32'd5, 32'd7, 32'h40);
    issue({6'h0A, 26'h0}, 32'h0, 32'h8000_0000, 32'd0, 32'd1);
    issue({6'h23, 26'h0}, 32'h0, 32'h1000, 32'hDEAD, 32'hFFFF_FFFC);

    held = {cond_o, result_o};
    for (int i = 0; i < 4; i++) begin
      en = 1'b0;
      instr_i = {6'h05, 26'h0}; opa_i = $urandom; npc_i = $urandom; imm_i = $urandom;
      @(posedge clk); @(negedge clk);
      compare("R2 stall", held);
    end

    for (int i = 0; i < 600; i++) begin
      logic [5:0]  op;
      logic [10:0] f;
      logic [31:0] a;
      case ($urandom_range(0, 11))
        0, 1, 2, 3: op = 6'h00;
        4: op = 6'h02;  5: op = 6'h03;  6: op = 6'h04;  7: op = 6'h05;
        8: op = 6'h0C;  9: op = 6'h0D;  10: op = 6'h0E;
        default: op = ($urandom_range(0, 1) == 0) ? 6'h0A : 6'($urandom);
      endcase
      case ($urandom_range(0, 9))
        0: f = 11'h020; 1: f = 11'h022; 2: f = 11'h024; 3: f = 11'h025;
        4: f = 11'h026; 5: f = 11'h004; 6: f = 11'h006; 7: f = 11'h007;
        8: f = 11'h02A; default: f = 11'($urandom);
      endcase
      a = ($urandom_range(0, 3) == 0) ? 32'd0 : $urandom;
      issue({op, 15'($urandom), f}, $urandom, a, $urandom, $urandom);
    end

    rst = 1'b1; en = 1'b1;
    @(posedge clk); @(negedge clk);
    compare("R1 reset mid-run", 33'd0);
    rst = 1'b0;
    issue({6'h0E, 26'h0}, 32'h0, 32'hFF00_FF00, 32'h0, 32'h0F0F_0F0F);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #2_000_000;
    fails++;
    $display("FAIL watchdog: got timeout, expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule